// File: doc/BRIEF.md
# PD packet 4b5b transmit framer

The framer turns one power-delivery message, a 16-bit header and up to seven 32-bit data words, into the sequence of 5-bit line symbols that a biphase-mark line coder puts on the wire. A single strobe starts a frame. The block then emits the full frame with no further help. The frame is a fixed alternating preamble, a start-of-packet ordered set built from K-codes, and the header, data and CRC-32 coded one nibble at a time. The CRC-32 is computed while the symbols are sent. The frame closes with an end-of-packet K-code. A second frame type sends the hard-reset ordered set after the preamble, with nothing behind it.

Symbols leave through a valid/ready handshake, so the line coder sets the pace. Two flags travel with each symbol. One marks a symbol that carries fewer than five bits, which happens at the tail of the preamble. The other marks the final symbol of the frame, so the line coder can add the closing edge. A one-cycle done pulse follows the final symbol. The framer ignores new strobes until that point.

Top module: `pd_tx_framer`

## Requirements
- R1: After reset, sym_valid_o, busy_o and done_o are low.
- R2: A frame opens with 13 preamble symbols carrying 64 bits that alternate, starting with 0. Bit 0 of each symbol goes on the line first, so even-numbered preamble symbols are 5'b01010 and odd-numbered ones are 5'b10101. Symbol 12 carries only its low 4 bits: it has sym_short_o high and its bit 4 is zero. No other symbol is short.
- R3: In a normal frame the preamble is followed by 5'b11000 three times and then 5'b10001.
- R4: Each nibble is coded as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. The header follows the start-of-packet set as four nibbles, least significant first.
- R5: The number of data words is header bits 14:12. Each word goes out after the header as eight nibbles, least significant first, which sends the low half-word before the high one.
- R6: After the data comes the CRC-32 of the header and the data words, sent as a word in the same way. The CRC uses polynomial 0x04C11DB7 with reflected input and output. It starts at 0xFFFFFFFF and is inverted at the end. Header bits and word bits enter least significant bit first.
- R7: A normal frame ends with 5'b01101, and that symbol is the only one in the frame with sym_last_o high.
- R8: A hard-reset frame (hard_reset_i high at the strobe) is the preamble, then 5'b00111 three times, then 5'b11001 with sym_last_o high, and nothing else. Header and data inputs do not affect it.
- R9: While sym_valid_o is high and sym_ready_i is low, sym_o and the flags stay unchanged. A symbol is consumed only on a cycle with both high.
- R10: done_o is high for exactly one cycle, the cycle after the last symbol is consumed, and busy_o and sym_valid_o are low in that cycle.
- R11: A strobe while busy_o is high is ignored. The running frame continues unchanged, and no new frame starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe, taken when idle |
| hard_reset_i | input | 1 | Frame type at the strobe: 1 hard reset, 0 normal message |
| header_i | input | 16 | Message header, count in bits 14:12 |
| data_i | input | 224 | Data words, word k in bits 32k+31:32k |
| sym_ready_i | input | 1 | Line coder accepts the symbol |
| sym_valid_o | output | 1 | sym_o holds a symbol |
| sym_o | output | 5 | Line symbol, bit 0 sent first |
| sym_short_o | output | 1 | Symbol carries only its low 4 bits |
| sym_last_o | output | 1 | Final symbol of the frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final symbol |

## Verification
The bench targets the edges between the frame sections. It covers a message with no data words, where a sequencer that failed to skip the data section would send stray symbols before the CRC. It covers a full seven-word message, where an off-by-one data count would shift the CRC and end-of-packet symbols. It also covers the short preamble tail, whose flag a wrong design would put on the wrong symbol or leave off. Back-pressure that stalls on a repeating pattern exposes a design that drops or repeats a symbol when ready is low. A strobe sent in the middle of a frame carries a different header and would corrupt or restart the frame if it were not ignored. A hard-reset strobe with a non-empty header would show a framer that wrongly appends message fields.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;
  typedef enum logic [2:0] {PH_PRE, PH_SOP, PH_HDR, PH_DATA, PH_CRC, PH_EOP} phase_e;

  localparam logic [4:0] K_SYNC1 = 5'b11000;
  localparam logic [4:0] K_SYNC2 = 5'b10001;
  localparam logic [4:0] K_RST1  = 5'b00111;
  localparam logic [4:0] K_RST2  = 5'b11001;
  localparam logic [4:0] K_EOP   = 5'b01101;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  function automatic logic [4:0] enc_nibble(input logic [3:0] n);
    logic [4:0] s;
    unique case (n)
      4'h0: s = 5'b11110;  4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;  4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;  4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;  4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;  4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;  4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;  4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;  default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // four reflected CRC steps, nibble bit 0 first
  function automatic logic [31:0] crc_step4(input logic [31:0] c, input logic [3:0] n);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      r = (r[0] ^ n[i]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/pd_tx_crc.sv
module pd_tx_crc (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [3:0]  nib_i,
  output logic [31:0] crc_o
);
  import pd_tx_pkg::*;
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (en_i)  crc_q <= crc_step4(crc_q, nib_i);
  end

  assign crc_o = ~crc_q;
endmodule

// File: rtl/pd_tx_seq.sv
module pd_tx_seq #(
  parameter int PRE_SYMS = 13,
  parameter int CNT_W    = 3,
  parameter int IDX_W    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 hard_i,
  input  logic [CNT_W-1:0]     words_i,
  input  logic                 adv_i,
  output logic                 busy_o,
  output logic                 hard_o,
  output pd_tx_pkg::phase_e    phase_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 done_o
);
  import pd_tx_pkg::*;

  logic             busy_q, hard_q, done_q;
  logic [CNT_W-1:0] words_q;
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q, data_last;

  assign data_last = IDX_W'({words_q, 3'b000}) - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      hard_q  <= 1'b0;
      done_q  <= 1'b0;
      words_q <= '0;
      phase_q <= PH_PRE;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          hard_q  <= hard_i;
          words_q <= words_i;
          phase_q <= PH_PRE;
          idx_q   <= '0;
        end
      end else if (adv_i) begin
        idx_q <= idx_q + IDX_W'(1);
        unique case (phase_q)
          PH_PRE: if (idx_q == IDX_W'(PRE_SYMS - 1)) begin
            phase_q <= PH_SOP;
            idx_q   <= '0;
          end
          PH_SOP: if (idx_q == IDX_W'(3)) begin
            if (hard_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              phase_q <= PH_HDR;
              idx_q   <= '0;
            end
          end
          PH_HDR: if (idx_q == IDX_W'(3)) begin
            phase_q <= (words_q == '0) ? PH_CRC : PH_DATA;
            idx_q   <= '0;
          end
          PH_DATA: if (idx_q == data_last) begin
            phase_q <= PH_CRC;
            idx_q   <= '0;
          end
          PH_CRC: if (idx_q == IDX_W'(7)) begin
            phase_q <= PH_EOP;
            idx_q   <= '0;
          end
          default: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy_o  = busy_q;
  assign hard_o  = hard_q;
  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;
endmodule

// File: rtl/pd_tx_enc.sv
module pd_tx_enc #(
  parameter int PRE_SYMS  = 13,
  parameter int PRE_TAIL  = 4,
  parameter int MAX_WORDS = 7,
  parameter int IDX_W     = 6
) (
  input  pd_tx_pkg::phase_e     phase_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  hard_i,
  input  logic [15:0]           header_i,
  input  logic [MAX_WORDS*32-1:0] data_i,
  input  logic [31:0]           crc_i,
  output logic [4:0]            sym_o,
  output logic                  short_o,
  output logic                  last_o,
  output logic [3:0]            nib_o
);
  import pd_tx_pkg::*;

  localparam logic [4:0] TAIL_MASK = (PRE_TAIL == 0) ? 5'h1F : 5'((1 << PRE_TAIL) - 1);

  logic pre_end;
  logic sop_end;
  assign pre_end = (idx_i == IDX_W'(PRE_SYMS - 1));
  assign sop_end = (idx_i == IDX_W'(3));

  always_comb begin
    unique case (phase_i)
      PH_HDR:  nib_o = header_i[{idx_i[1:0], 2'b00} +: 4];
      PH_DATA: nib_o = data_i[{idx_i, 2'b00} +: 4];
      PH_CRC:  nib_o = crc_i[{idx_i[2:0], 2'b00} +: 4];
      default: nib_o = 4'h0;
    endcase
  end

  always_comb begin
    short_o = 1'b0;
    last_o  = 1'b0;
    unique case (phase_i)
      PH_PRE: begin
        // 5 is odd: bit parity of a symbol's first bit follows the symbol index
        sym_o   = idx_i[0] ? 5'b10101 : 5'b01010;
        short_o = pre_end && (PRE_TAIL != 0);
        if (short_o) sym_o = sym_o & TAIL_MASK;
      end
      PH_SOP: begin
        if (hard_i) sym_o = sop_end ? K_RST2 : K_RST1;
        else        sym_o = sop_end ? K_SYNC2 : K_SYNC1;
        last_o = hard_i && sop_end;
      end
      PH_EOP: begin
        sym_o  = K_EOP;
        last_o = 1'b1;
      end
      default: sym_o = enc_nibble(nib_o);
    endcase
  end
endmodule

// File: rtl/pd_tx_framer.sv
module pd_tx_framer #(
  parameter int MAX_WORDS = 7,
  parameter int PRE_BITS  = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    hard_reset_i,
  input  logic [15:0]             header_i,
  input  logic [MAX_WORDS*32-1:0] data_i,
  input  logic                    sym_ready_i,
  output logic                    sym_valid_o,
  output logic [4:0]              sym_o,
  output logic                    sym_short_o,
  output logic                    sym_last_o,
  output logic                    busy_o,
  output logic                    done_o
);
  import pd_tx_pkg::*;

  localparam int CNT_W    = 3;
  localparam int PRE_SYMS = (PRE_BITS + 4) / 5;
  localparam int PRE_TAIL = PRE_BITS % 5;
  localparam int NIB_MAX  = MAX_WORDS * 8;
  localparam int IDX_MAX  = (NIB_MAX > PRE_SYMS) ? NIB_MAX : PRE_SYMS;
  localparam int IDX_W    = $clog2(IDX_MAX + 1);

  logic                    busy, hard_q, adv, accept, crc_en;
  logic [15:0]             header_q;
  logic [MAX_WORDS*32-1:0] data_q;
  logic [CNT_W-1:0]        hdr_cnt, words;
  phase_e                  phase;
  logic [IDX_W-1:0]        idx;
  logic [31:0]             crc;
  logic [3:0]              nib;

  assign hdr_cnt = header_i[14:12];
  assign words   = (int'(hdr_cnt) > MAX_WORDS) ? CNT_W'(MAX_WORDS) : hdr_cnt;
  assign accept  = start_i && !busy;
  assign adv     = busy && sym_ready_i;
  assign crc_en  = adv && (phase == PH_HDR || phase == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      header_q <= '0;
      data_q   <= '0;
    end else if (accept) begin
      header_q <= header_i;
      data_q   <= data_i;
    end
  end

  pd_tx_seq #(.PRE_SYMS(PRE_SYMS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .hard_i(hard_reset_i), .words_i(words), .adv_i(adv),
    .busy_o(busy), .hard_o(hard_q), .phase_o(phase), .idx_o(idx), .done_o(done_o)
  );

  pd_tx_crc u_crc (
    .clk_i, .rst_ni, .clr_i(accept), .en_i(crc_en), .nib_i(nib), .crc_o(crc)
  );

  pd_tx_enc #(.PRE_SYMS(PRE_SYMS), .PRE_TAIL(PRE_TAIL), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)) u_enc (
    .phase_i(phase), .idx_i(idx), .hard_i(hard_q), .header_i(header_q), .data_i(data_q),
    .crc_i(crc), .sym_o(sym_o), .short_o(sym_short_o), .last_o(sym_last_o), .nib_o(nib)
  );

  assign sym_valid_o = busy;
  assign busy_o      = busy;
endmodule

// File: rtl/pd_tx_framer_chk.sv
module pd_tx_framer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       sym_ready_i,
  input logic       sym_valid_o,
  input logic [4:0] sym_o,
  input logic       sym_short_o,
  input logic       sym_last_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       hard_q
);
  a_r9_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && !sym_ready_i |=> sym_valid_o && $stable(sym_o) && $stable(sym_last_o) && $stable(sym_short_o));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && sym_ready_i && sym_last_o |=> done_o && !busy_o);

  a_r2_short_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && sym_short_o |-> !sym_last_o && !sym_o[4]);

  a_r7_eop_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && sym_last_o && !hard_q |-> sym_o == 5'b01101);

  a_r8_rst2_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && sym_last_o && hard_q |-> sym_o == 5'b11001);

  a_r11_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !(sym_ready_i && sym_last_o) |=> busy_o && !done_o);
endmodule

bind pd_tx_framer pd_tx_framer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sym_ready_i(sym_ready_i),
  .sym_valid_o(sym_valid_o), .sym_o(sym_o), .sym_short_o(sym_short_o),
  .sym_last_o(sym_last_o), .busy_o(busy_o), .done_o(done_o), .hard_q(hard_q)
);

// File: tb/pd_tx_framer_bench.sv
module pd_tx_framer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         hard = 1'b0;
  logic [15:0]  header = '0;
  logic [223:0] data = '0;
  logic         ready = 1'b0;
  logic         valid, sshort, slast, busy, done;
  logic [4:0]   sym;

  int total = 0;
  int bad = 0;

  logic [6:0] exp_s [0:127];
  logic [6:0] got_s [0:127];
  int exp_n, got_n;

  always #4 clk = ~clk;

  pd_tx_framer u_pd_tx_framer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hard_reset_i(hard),
    .header_i(header), .data_i(data), .sym_ready_i(ready), .sym_valid_o(valid),
    .sym_o(sym), .sym_short_o(sshort), .sym_last_o(slast), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [4:0] code4(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c = c ^ 32'hEDB88320;
    return c;
  endfunction

  task automatic push(input logic s, input logic l, input logic [4:0] v);
    exp_s[exp_n] = {s, l, v};
    exp_n++;
  endtask

  task automatic build(input logic hr, input logic [15:0] h, input logic [223:0] d);
    logic [31:0] c;
    logic [4:0] p;
    int nw;
    exp_n = 0;
    for (int k = 0; k < 13; k++) begin
      p = '0;
      for (int j = 0; j < 5; j++) if (k * 5 + j < 64) p[j] = (((k * 5 + j) % 2) == 1);
      push(k == 12, 1'b0, p);
    end
    for (int k = 0; k < 3; k++) push(1'b0, 1'b0, hr ? 5'b00111 : 5'b11000);
    push(1'b0, hr, hr ? 5'b11001 : 5'b10001);
    if (!hr) begin
      nw = int'(h[14:12]);
      for (int i = 0; i < 4; i++) push(1'b0, 1'b0, code4(h[i*4 +: 4]));
      for (int w = 0; w < nw; w++)
        for (int i = 0; i < 8; i++) push(1'b0, 1'b0, code4(d[w*32 + i*4 +: 4]));
      c = 32'hFFFFFFFF;
      for (int b = 0; b < 16; b++) c = crc_bit(c, h[b]);
      for (int w = 0; w < nw; w++)
        for (int b = 0; b < 32; b++) c = crc_bit(c, d[w*32 + b]);
      c = ~c;
      for (int i = 0; i < 8; i++) push(1'b0, 1'b0, code4(c[i*4 +: 4]));
      push(1'b0, 1'b1, 5'b01101);
    end
  endtask

  // mode 0: always ready, 1: stall pattern, 2: ready plus a strobe mid-frame
  task automatic run_frame(input string tag, input logic hr, input logic [15:0] h,
                           input logic [223:0] d, input int mode);
    int cyc, mism, first_bad, hold_err;
    logic stalled;
    logic [6:0] held;
    build(hr, h, d);
    @(negedge clk);
    hard = hr; header = h; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_n = 0; cyc = 0; hold_err = 0; stalled = 1'b0; held = '0;
    while (cyc < 1000) begin
      @(negedge clk);
      start = 1'b0;
      if (mode == 2 && cyc == 30) begin
        start = 1'b1; hard = ~hr; header = 16'h7FFF; data = '1;
      end
      ready = (mode == 1) ? ((cyc % 3) != 1) : 1'b1;
      #2;
      if (stalled && (!valid || {sshort, slast, sym} !== held)) hold_err++;
      stalled = valid && !ready;
      held = {sshort, slast, sym};
      if (valid && ready) begin
        if (got_n < 128) got_s[got_n] = {sshort, slast, sym};
        got_n++;
        if (slast) break;
      end
      cyc++;
    end
    @(negedge clk);
    ready = 1'b0; start = 1'b0;
    #2;
    check({tag, " done pulse"}, {62'd0, done, busy}, 64'd2);
    check({tag, " length"}, 64'(got_n), 64'(exp_n));
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n && i < 128; i++)
      if (got_s[i] !== exp_s[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    if (first_bad >= 0)
      check({tag, " stream"}, 64'(got_s[first_bad]), 64'(exp_s[first_bad]));
    else
      check({tag, " stream"}, 64'(mism), 64'd0);
    if (mode == 1) check({tag, " R9 stall hold"}, 64'(hold_err), 64'd0);
    @(negedge clk);
    #2;
    check({tag, " R10 done drops"}, {62'd0, done, valid}, 64'd0);
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {61'd0, valid, busy, done}, 64'd0);
  endtask

  task automatic t_hard;
    run_frame("R8 R2 hard reset", 1'b1, 16'h3123, {7{32'hDEADBEEF}}, 0);
    check("R2 tail short", {57'd0, got_s[12]}, {57'd0, 7'b1_0_01010});
    check("R2 preamble odd", {57'd0, got_s[1]}, {57'd0, 7'b0_0_10101});
    check("R8 final RST-2", {57'd0, got_s[16]}, {57'd0, 7'b0_1_11001});
  endtask

  task automatic t_empty;
    run_frame("R3 R4 R6 R7 no data", 1'b0, 16'h0A41, '0, 0);
    check("R3 sync-1", {57'd0, got_s[13]}, {57'd0, 7'b0_0_11000});
    check("R3 sync-2", {57'd0, got_s[16]}, {57'd0, 7'b0_0_10001});
    check("R4 header low nibble", {57'd0, got_s[17]}, {57'd0, 7'b0_0_01001});
    check("R7 EOP", {57'd0, got_s[exp_n-1]}, {57'd0, 7'b0_1_01101});
  endtask

  task automatic t_full;
    logic [223:0] d;
    for (int w = 0; w < 7; w++) d[w*32 +: 32] = 32'h01234567 + 32'(w) * 32'h11111111;
    run_frame("R5 R6 seven words", 1'b0, 16'h71A2, d, 0);
  endtask

  task automatic t_stall;
    run_frame("R9 R5 two words stall", 1'b0, 16'h2C5F, {160'd0, 32'hCAFEF00D, 32'h89ABCDEF}, 1);
  endtask

  task automatic t_busy_start;
    run_frame("R11 strobe while busy", 1'b0, 16'h1003, {192'd0, 32'h5A5AA5A5}, 2);
    @(negedge clk);
    #2;
    check("R11 no second frame", {63'd0, valid}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #21;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hard();
    t_empty();
    t_full();
    t_stall();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule